// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a memory-mapped management master for Clause 45 PHY register access over a two-wire MDIO bus. Software first places a 16-bit register address in an address register. It then writes a command word to the management register. That word carries the target port address, the device address, a 3-bit command code and, for writes, the 16-bit write data.

Each accepted command is sequenced in hardware with no further software action. An address frame carries the address register contents. After one idle MDC cycle, a write frame or a read frame follows. Software polls the busy bit in the management register. After a read, it finds the returned 16-bit value in the low half of that register, with a read-valid flag beside it.

MDC runs only while a command is in flight. Its half period is a parameter counted in system clocks. MDIO is driven on falling MDC edges and sampled on rising ones. The master lets go of the MDIO line for the turnaround and data bits of a read frame.

Top module: `mdio45_top`

## Requirements
- R1: After reset, busy (management bit 30) and read-valid (bit 29) are 0, MDC is low and MDIO is not driven.
- R2: A write to offset 0x8 stores bits 15:0 as the register address, and a read of offset 0x8 returns that value zero-extended. Register addresses may be written at any time.
- R3: A write to offset 0x0 while idle, with command code 5 in bits 28:26, sets busy in the next cycle. It latches the port address (bits 20:16), the device address (bits 25:21), the code and the data (bits 15:0), and all of these read back in the same positions. It then sends two frames. The first is 32 ones, start 00, op 00, port, device, turnaround 10 and the address register. The second is 32 ones, start 00, op 01, port, device, turnaround 10 and the write data. Both are sent MSB first, and MDIO changes only while MDC is low.
- R4: Command code 7 sends the same address frame followed by a read frame with op 11. In the read frame the master drives bits 0 to 45 and releases MDIO for the two turnaround bits and the 16 data bits.
- R5: In a read frame, the 16 data bits are sampled on rising MDC edges, MSB first. They appear in management bits 15:0, and read-valid is set as busy clears. Read-valid is cleared when the next command is accepted.
- R6: A write to offset 0x0 while busy is ignored. The latched fields are unchanged and no extra frame is sent.
- R7: The address frame carries the address register value at the moment the command is accepted. Later writes to offset 0x8 do not change it.
- R8: A write to offset 0x0 whose command code is neither 5 nor 7 is ignored. Busy stays 0, the fields are unchanged and no frame is sent.
- R9: The two frames of one command are separated by at least one MDC rising edge with MDIO released.
- R10: Each MDC level lasts MDC_HALF clocks, and MDC is low and MDIO is released while idle. Busy lasts exactly 258*MDC_HALF cycles per command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWr | input | 1 | Register write strobe |
| cpuAddr | input | 4 | Register byte offset (0x0 management, 0x8 address) |
| cpuWdata | input | 32 | Register write data |
| cpuRdata | output | 32 | Register read data for cpuAddr, combinational |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value driven by the master |
| mdioOe | output | 1 | MDIO drive enable, 1 while the master drives |
| mdioIn | input | 1 | MDIO value seen on the line |

## Verification
- **Register side:** A command write is taken on the rising edge that follows it, so busy is checked at the very next falling clock edge. The bench then counts falling edges until busy drops and expects exactly 258*MDC_HALF.
- **Readback:** The register read path is combinational, so readback is sampled 1 ns after cpuAddr settles, away from any edge.
- **Frame monitor:** Frame bits are collected on every rising MDC edge and compared, frame by frame, against a scoreboard queue filled when each command is issued.
- **PHY stand-in:** The bench drives read data 1 ns after a rising MDC edge, so the value is stable at the next rising edge, where the master samples it.
- **Read results:** Read data and read-valid are checked only after busy has dropped.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;

  localparam int CPU_AW     = 4;
  localparam int PORT_W     = 5;
  localparam int DEV_W      = 5;
  localparam int REG_W      = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + PORT_W + DEV_W + 2 + REG_W;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int TA_FIRST   = PRE_BITS + 2 + 2 + PORT_W + DEV_W;
  localparam int DATA_FIRST = TA_FIRST + 2;

  localparam logic [CPU_AW-1:0] OFS_MGMT = 4'h0;
  localparam logic [CPU_AW-1:0] OFS_ADDR = 4'h8;

  localparam int PORT_LSB  = 16;
  localparam int DEV_LSB   = 21;
  localparam int CODE_LSB  = 26;
  localparam int VALID_BIT = 29;
  localparam int BUSY_BIT  = 30;

  localparam logic [2:0] CODE_WRITE = 3'd5;
  localparam logic [2:0] CODE_READ  = 3'd7;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_GAP, ST_DATA} stateT;

  typedef struct packed {
    logic accept;    // command taken, latch fields and address frame
    logic loadData;  // load the second frame
    logic shift;     // advance to the next frame bit
    logic capture;   // sample one read data bit
    logic setValid;  // read data complete
  } strobeT;

  function automatic logic [FRAME_BITS-1:0] buildFrame(
      input logic [1:0]       op,
      input logic [PORT_W-1:0] port,
      input logic [DEV_W-1:0]  dev,
      input logic [REG_W-1:0]  payload);
    return {{PRE_BITS{1'b1}}, 2'b00, op, port, dev, 2'b10, payload};
  endfunction

endpackage

// File: rtl/mdio45_ctrl.sv
module mdio45_ctrl
  import mdio45_pkg::*;
#(
  parameter int MDC_HALF = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWrite,
  input  logic [2:0] cmdCode,
  output strobeT     strb,
  output logic       busy,
  output logic       mdc,
  output logic       mdioOe
);

  localparam int DIV_W = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(MDC_HALF - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] TA_IDX   = BIT_W'(TA_FIRST);
  localparam logic [BIT_W-1:0] DATA_IDX = BIT_W'(DATA_FIRST);

  stateT            state;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             readCmd;
  logic             codeOk, tick, riseTick, fallTick, lastBit;

  assign codeOk   = (cmdCode == CODE_WRITE) || (cmdCode == CODE_READ);
  assign tick     = (state != ST_IDLE) && (divCnt == DIV_LAST);
  assign riseTick = tick && !mdc;
  assign fallTick = tick && mdc;
  assign lastBit  = (bitIdx == LAST_BIT);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strb          = '0;
    strb.accept   = (state == ST_IDLE) && cmdWrite && codeOk;
    strb.loadData = fallTick && (state == ST_GAP);
    strb.shift    = fallTick && ((state == ST_ADDR) || (state == ST_DATA)) && !lastBit;
    strb.capture  = riseTick && (state == ST_DATA) && readCmd && (bitIdx >= DATA_IDX);
    strb.setValid = fallTick && (state == ST_DATA) && readCmd && lastBit;
  end

  always_comb begin
    mdioOe = (state == ST_ADDR) ||
             ((state == ST_DATA) && !(readCmd && (bitIdx >= TA_IDX)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      bitIdx  <= '0;
      readCmd <= 1'b0;
      mdc     <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (strb.accept) begin
        state   <= ST_ADDR;
        readCmd <= (cmdCode == CODE_READ);
        divCnt  <= '0;
        bitIdx  <= '0;
      end
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) mdc <= ~mdc;
      if (fallTick) begin
        unique case (state)
          ST_ADDR: begin
            if (lastBit) begin
              state  <= ST_GAP;
              bitIdx <= '0;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end
          ST_GAP: state <= ST_DATA;
          ST_DATA: begin
            if (lastBit) state <= ST_IDLE;
            else         bitIdx <= bitIdx + 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/mdio45_dp.sv
module mdio45_dp
  import mdio45_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic              busy,
  input  logic              cpuWr,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [31:0]       cpuWdata,
  input  logic              mdioIn,
  output logic [31:0]       cpuRdata,
  output logic              mdioOut
);

  logic [REG_W-1:0]      addrReg;
  logic [PORT_W-1:0]     portQ;
  logic [DEV_W-1:0]      devQ;
  logic [2:0]            codeQ;
  logic [REG_W-1:0]      dataQ;
  logic                  validQ;
  logic [FRAME_BITS-1:0] frameSr;
  logic                  unusedWdata;

  assign unusedWdata = ^cpuWdata[31:29];
  assign mdioOut     = frameSr[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (cpuWr && (cpuAddr == OFS_ADDR)) begin
      addrReg <= cpuWdata[REG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portQ   <= '0;
      devQ    <= '0;
      codeQ   <= '0;
      dataQ   <= '0;
      validQ  <= 1'b0;
      frameSr <= '0;
    end else begin
      if (strb.accept) begin
        portQ   <= cpuWdata[PORT_LSB +: PORT_W];
        devQ    <= cpuWdata[DEV_LSB +: DEV_W];
        codeQ   <= cpuWdata[CODE_LSB +: 3];
        dataQ   <= cpuWdata[REG_W-1:0];
        validQ  <= 1'b0;
        frameSr <= buildFrame(2'b00, cpuWdata[PORT_LSB +: PORT_W],
                              cpuWdata[DEV_LSB +: DEV_W], addrReg);
      end else if (strb.loadData) begin
        frameSr <= (codeQ == CODE_READ) ? buildFrame(2'b11, portQ, devQ, '0)
                                        : buildFrame(2'b01, portQ, devQ, dataQ);
      end else if (strb.shift) begin
        frameSr <= {frameSr[FRAME_BITS-2:0], 1'b0};
      end
      if (strb.capture)  dataQ  <= {dataQ[REG_W-2:0], mdioIn};
      if (strb.setValid) validQ <= 1'b1;
    end
  end

  always_comb begin
    cpuRdata = '0;
    unique case (cpuAddr)
      OFS_MGMT: begin
        cpuRdata[REG_W-1:0]           = dataQ;
        cpuRdata[PORT_LSB +: PORT_W]  = portQ;
        cpuRdata[DEV_LSB +: DEV_W]    = devQ;
        cpuRdata[CODE_LSB +: 3]       = codeQ;
        cpuRdata[VALID_BIT]           = validQ;
        cpuRdata[BUSY_BIT]            = busy;
      end
      OFS_ADDR: cpuRdata[REG_W-1:0] = addrReg;
      default:  cpuRdata = '0;
    endcase
  end

endmodule

// File: rtl/mdio45_top.sv
module mdio45_top
  import mdio45_pkg::*;
#(
  parameter int MDC_HALF = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuWr,
  input  logic [3:0]  cpuAddr,
  input  logic [31:0] cpuWdata,
  output logic [31:0] cpuRdata,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  strobeT strb;
  logic   busy;
  logic   cmdWrite;

  assign cmdWrite = cpuWr && (cpuAddr == OFS_MGMT);

  mdio45_ctrl #(.MDC_HALF(MDC_HALF)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdWrite(cmdWrite),
    .cmdCode (cpuWdata[CODE_LSB +: 3]),
    .strb    (strb),
    .busy    (busy),
    .mdc     (mdc),
    .mdioOe  (mdioOe)
  );

  mdio45_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busy    (busy),
    .cpuWr   (cpuWr),
    .cpuAddr (cpuAddr),
    .cpuWdata(cpuWdata),
    .mdioIn  (mdioIn),
    .cpuRdata(cpuRdata),
    .mdioOut (mdioOut)
  );

endmodule

// File: rtl/mdio45_chk.sv
module mdio45_chk
  import mdio45_pkg::*;
#(
  parameter int MDC_HALF = 2
) (
  input logic   clk,
  input logic   rstN,
  input strobeT strb,
  input logic   busy,
  input logic   validQ,
  input logic   mdc,
  input logic   mdioOut,
  input logic   mdioOe
);

  logic        mdcPrev;
  logic [15:0] heldCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mdcPrev <= 1'b0;
      heldCnt <= 16'hFFFF;
    end else begin
      mdcPrev <= mdc;
      if (mdc != mdcPrev)        heldCnt <= '0;
      else if (heldCnt != 16'hFFFF) heldCnt <= heldCnt + 1'b1;
    end
  end

  // R10: quiet bus while no command is in flight
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  // R10: no MDC level is shorter than MDC_HALF clocks
  assert_mdc_level_R10: assert property (@(posedge clk) disable iff (!rstN)
    (mdc != mdcPrev) |-> (heldCnt >= 16'(MDC_HALF - 1)));

  // R3: driven data only moves while MDC is low
  assert_data_on_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (mdioOe && !$stable(mdioOut)) |-> !mdc);

  // R5: a newly accepted command drops read-valid
  assert_valid_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> (!validQ && busy));

endmodule

bind mdio45_top mdio45_chk #(.MDC_HALF(MDC_HALF)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .strb   (strb),
  .busy   (busy),
  .validQ (u_dp.validQ),
  .mdc    (mdc),
  .mdioOut(mdioOut),
  .mdioOe (mdioOe)
);

// File: tb/sim_mdio45_top.sv
`timescale 1ns/1ps
module sim_mdio45_top;

  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuWr = 1'b0;
  logic [3:0]  cpuAddr = 4'h0;
  logic [31:0] cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b0;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [63:0] bits;
    logic [63:0] mask;
    string       req;
  } frameT;
  frameT expQ[$];

  logic [15:0] phyData = '0;

  always #2.5 clk = ~clk;

  mdio45_top #(.MDC_HALF(HALF)) u0 (
    .clk(clk), .rstN(rstN), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmdWord(input logic [2:0] code, input logic [4:0] port,
                                          input logic [4:0] dev, input logic [15:0] data);
    return {3'b000, code, dev, port, data};
  endfunction

  // driver side of the scoreboard: expected frames for one command
  task automatic pushCmd(input logic [2:0] code, input logic [4:0] port, input logic [4:0] dev,
                         input logic [15:0] data, input logic [15:0] regAddr);
    frameT f;
    f.bits = {32'hFFFF_FFFF, 2'b00, 2'b00, port, dev, 2'b10, regAddr};
    f.mask = '1;
    f.req  = "R3/R7 address frame";
    expQ.push_back(f);
    if (code == 3'd7) begin
      f.bits = {32'hFFFF_FFFF, 2'b00, 2'b11, port, dev, 18'h0};
      f.mask = ~64'h3FFFF;
      f.req  = "R4 read frame";
    end else begin
      f.bits = {32'hFFFF_FFFF, 2'b00, 2'b01, port, dev, 2'b10, data};
      f.mask = '1;
      f.req  = "R3 write frame";
    end
    expQ.push_back(f);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWdata = d; cpuWr = 1'b1;
    @(negedge clk);
    cpuWr = 1'b0; cpuAddr = 4'h0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    cpuAddr = a;
    #1 v = cpuRdata;
  endtask

  task automatic waitIdle(input string req);
    logic [31:0] v;
    int n = 0;
    rd(4'h0, v);
    while (v[30] && n < 5000) begin
      rd(4'h0, v);
      n++;
    end
    chk(req, {63'h0, v[30]}, 64'h0);
  endtask

  // monitor side: frame collection on rising MDC, PHY read data drive
  int          bitK = -1;
  int          idleRun = 0;
  logic [63:0] gotBits = '0;
  logic [63:0] gotMask = '0;
  logic        isRd = 1'b0;

  always @(posedge mdc) begin
    if (bitK < 0) begin
      if (mdioOe) begin
        bitK = 0;
        isRd = 1'b0;
        if (expQ.size() > 0 && expQ[0].bits[29:28] != 2'b00)
          chk("R9 idle MDC edges between frames", {63'h0, idleRun >= 1}, 64'h1);
      end else begin
        idleRun++;
      end
    end
    if (bitK >= 0) begin
      gotBits = {gotBits[62:0], mdioOe ? mdioOut : 1'b0};
      gotMask = {gotMask[62:0], mdioOe};
      if (bitK == 35) isRd = (gotBits[1:0] == 2'b11);
      if (isRd && bitK >= 47 && bitK <= 62) mdioIn <= #1 phyData[15 - (bitK - 47)];
      if (bitK == 63) begin
        mdioIn <= #1 1'b0;
        if (expQ.size() == 0) begin
          chk("R6/R8 unexpected frame", gotBits, 64'h0);
        end else begin
          frameT f;
          f = expQ.pop_front();
          chk(f.req, gotBits, f.bits);
          chk({f.req, " drive mask"}, gotMask, f.mask);
        end
        bitK = -1;
        idleRun = 0;
      end else begin
        bitK++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R10 act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cnt;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(4'h0, v);
    chk("R1 reset busy/valid/mdc/oe", {60'h0, v[30], v[29], mdc, mdioOe}, 64'h0);

    // R2 address register
    wr(4'h8, 32'hABCD_1234);
    rd(4'h8, v);
    chk("R2 address readback", {32'h0, v}, 64'h1234);

    // R3 write command, R10 busy duration
    pushCmd(3'd5, 5'd3, 5'd1, 16'hBEEF, 16'h1234);
    wr(4'h0, cmdWord(3'd5, 5'd3, 5'd1, 16'hBEEF));
    #1 v = cpuRdata;
    chk("R3 busy next cycle", {63'h0, v[30]}, 64'h1);
    cnt = 1;
    forever begin
      rd(4'h0, v);
      if (!v[30] || cnt > 5000) break;
      cnt++;
    end
    chk("R10 busy length", 64'(cnt), 64'(258 * HALF));
    chk("R3 field readback", {35'h0, v[28:0]}, {35'h0, 3'd5, 5'd1, 5'd3, 16'hBEEF});
    chk("R3 no valid after write", {63'h0, v[29]}, 64'h0);
    chk("R3 frames done", 64'(expQ.size()), 64'h0);

    // R4/R5 read, R6 ignored command, R7 address sampled at accept
    phyData = 16'h5AA5;
    wr(4'h8, 32'h0000_A5C3);
    pushCmd(3'd7, 5'h1F, 5'h1E, 16'h0, 16'hA5C3);
    wr(4'h0, cmdWord(3'd7, 5'h1F, 5'h1E, 16'h0));
    repeat (20) @(negedge clk);
    wr(4'h0, cmdWord(3'd5, 5'd2, 5'd2, 16'h1111));
    wr(4'h8, 32'h0000_7777);
    rd(4'h8, v);
    chk("R7 address register updated while busy", {32'h0, v}, 64'h7777);
    waitIdle("R4 read completes");
    rd(4'h0, v);
    chk("R5 read data and valid", {34'h0, v[29:0]},
        {34'h0, 1'b1, 3'd7, 5'h1E, 5'h1F, 16'h5AA5});
    chk("R6 R7 frame count", 64'(expQ.size()), 64'h0);

    // R8 unsupported code ignored
    wr(4'h0, cmdWord(3'd3, 5'd4, 5'd4, 16'h0));
    rd(4'h0, v);
    chk("R8 no busy", {63'h0, v[30]}, 64'h0);
    repeat (600) @(negedge clk);
    rd(4'h0, v);
    chk("R8 fields unchanged", {34'h0, v[29:0]},
        {34'h0, 1'b1, 3'd7, 5'h1E, 5'h1F, 16'h5AA5});
    chk("R8 bus quiet", {62'h0, mdc, mdioOe}, 64'h0);

    // R5 valid cleared by next command, boundary values
    wr(4'h8, 32'h0000_0000);
    pushCmd(3'd5, 5'd0, 5'd0, 16'hFFFF, 16'h0000);
    wr(4'h0, cmdWord(3'd5, 5'd0, 5'd0, 16'hFFFF));
    #1 v = cpuRdata;
    chk("R5 valid cleared on accept", {62'h0, v[30], v[29]}, 64'h2);
    waitIdle("R3 boundary write completes");

    phyData = 16'h8001;
    wr(4'h8, 32'h0000_FFFF);
    pushCmd(3'd7, 5'd0, 5'd0, 16'h0, 16'hFFFF);
    wr(4'h0, cmdWord(3'd7, 5'd0, 5'd0, 16'h0));
    waitIdle("R4 second read completes");
    rd(4'h0, v);
    chk("R5 MSB-first capture", {47'h0, v[29], v[15:0]}, {47'h0, 1'b1, 16'h8001});
    chk("R4 frames done", 64'(expQ.size()), 64'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule